// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs read and write cycles to external memory or I/O over one shared 8-bit bus that carries the address first and the data after it. Three control lines frame each cycle:
- an active-low address strobe,
- an active-low data strobe,
- a direction line that is high for a read and low for a write.

The bus has separate drive, output-enable and sample signals, so a pad ring can build the tri-state pin from them.

A client offers a request with an address, write data, a direction and an extended-timing flag. The block takes the request only while it is idle. It steps through a fixed series of system-clock states and then pulses a done signal. Read data is captured when the data strobe rises and is held on the response port.

The data-strobe phase is longer for reads than for writes. When the extended flag is set, the phase gets extra states, two by default.

Top module: `mbus_ctrl`

## Requirements
- R1: After reset, and between cycles, both strobes are high (1), the direction line is high, the bus output-enable is low (0), req_ready is high and rsp_done is low.
- R2: A request is taken only when req_ready is high at a rising clock edge. A request raised while a cycle is in progress starts no bus cycle and changes no memory location.
- R3: The address is driven on the bus, with output-enable high, for one state before the address strobe falls. It stays driven, unchanged, for the whole address-strobe low state.
- R4: The address strobe is low for exactly one state in each cycle.
- R5: After the address strobe rises, the data strobe stays high for one turnaround state. In a read, the output-enable is low in that state and stays low through the data-strobe phase.
- R6: The direction line is low for a write and high for a read. It holds its value from the address-strobe state through the state after the data strobe rises.
- R7: Without extended timing, the data strobe is low for RD_STATES states (default 3) in a read and WR_STATES states (default 2) in a write.
- R8: With ext_mode set at acceptance, the data strobe is low for EXT_STATES (default 2) more states than R7 gives, for both reads and writes.
- R9: rsp_rdata takes the value of bus_ad_in from the last data-strobe low state of a read. It keeps that value through later write cycles.
- R10: In a write, the write data is driven with output-enable high from the turnaround state through the state after the data strobe rises.
- R11: rsp_done is high for exactly one clock, in the state after the data strobe rises. req_ready is high in the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, a request is taken at this edge |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | DATA_W | Cycle address |
| req_wdata | input | DATA_W | Write data |
| ext_mode | input | 1 | Stretch the data-strobe phase |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_ad_out | output | DATA_W | Value driven on the shared bus |
| bus_ad_oe | output | 1 | Bus output-enable |
| bus_ad_in | input | DATA_W | Value sampled from the shared bus |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_rw_n | output | 1 | Direction: high read, low write |

## Verification
The test mixes these input patterns:
- plain reads and writes, which separate the two data-strobe lengths;
- the same cycles with the extended flag set, which shows that the stretch applies to both directions;
- a write followed by a read of the same address, which tests the write-data path against the capture path;
- back-to-back requests, which expose an off-by-one in the return to idle;
- a request raised mid-cycle, which must leave no trace on the bus or in memory.

The bench drives the read bus with a filler value except during the data-strobe low states. A capture taken at any other moment therefore shows up as a wrong value.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ADDR = 3'd1,
      ST_ASTB = 3'd2,
      ST_TURN = 3'd3,
      ST_DSTB = 3'd4,
      ST_DONE = 3'd5
   } mbus_state_e;

endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
   import mbus_pkg::*;
#(
   parameter int RD_STATES  = 3,
   parameter int WR_STATES  = 2,
   parameter int EXT_STATES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        is_write,
   input  logic        ext_on,
   output mbus_state_e state,
   output logic        last_beat
);

   localparam int BASE_MAX = (RD_STATES > WR_STATES) ? RD_STATES : WR_STATES;
   localparam int MAX_LEN  = BASE_MAX + EXT_STATES;
   localparam int CNT_W    = $clog2(MAX_LEN + 1);

   mbus_state_e      nxt;
   logic [CNT_W-1:0] base_len;
   logic [CNT_W-1:0] ext_add;
   logic [CNT_W-1:0] beat_len;
   logic [CNT_W-1:0] cnt;

   initial begin : prm_chk
      assert (RD_STATES >= 1) else $error("RD_STATES must be at least 1");
      assert (WR_STATES >= 1) else $error("WR_STATES must be at least 1");
      assert (EXT_STATES >= 0) else $error("EXT_STATES must not be negative");
   end

   assign base_len = is_write ? CNT_W'(WR_STATES) : CNT_W'(RD_STATES);

   generate
      if (EXT_STATES > 0) begin : g_ext
         assign ext_add = ext_on ? CNT_W'(EXT_STATES) : '0;
      end else begin : g_noext
         assign ext_add = '0;
      end
   endgenerate

   assign beat_len  = base_len + ext_add;
   assign last_beat = (state == ST_DSTB) && (cnt == CNT_W'(1));

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: if (start) nxt = ST_ADDR;
         ST_ADDR: nxt = ST_ASTB;
         ST_ASTB: nxt = ST_TURN;
         ST_TURN: nxt = ST_DSTB;
         ST_DSTB: if (last_beat) nxt = ST_DONE;
         ST_DONE: nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         state <= nxt;
         if (state == ST_TURN)
            cnt <= beat_len;
         else if (state == ST_DSTB)
            cnt <= cnt - CNT_W'(1);
      end
   end

   // R7
   beat_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DSTB) |-> (cnt != '0));

   // R4
   astb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ASTB) |=> (state == ST_TURN));

endmodule

// File: rtl/mbus_dp.sv
module mbus_dp
   import mbus_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              req_write,
   input  logic              ext_mode,
   input  logic [DATA_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  mbus_state_e       state,
   input  logic              last_beat,
   input  logic [DATA_W-1:0] bus_ad_in,
   output logic              wr_lat,
   output logic              ext_lat,
   output logic [DATA_W-1:0] bus_ad_out,
   output logic              bus_ad_oe,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] addr_lat;
   logic [DATA_W-1:0] wdata_lat;
   logic              addr_phase;
   logic              data_phase;

   initial begin : prm_chk
      assert (DATA_W >= 1) else $error("DATA_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_lat  <= '0;
         wdata_lat <= '0;
         wr_lat    <= 1'b0;
         ext_lat   <= 1'b0;
      end else if (start) begin
         addr_lat  <= req_addr;
         wdata_lat <= req_wdata;
         wr_lat    <= req_write;
         ext_lat   <= ext_mode;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (last_beat && !wr_lat)
         rdata <= bus_ad_in;
   end

   assign addr_phase = (state == ST_ADDR) || (state == ST_ASTB);
   assign data_phase = (state == ST_TURN) || (state == ST_DSTB) || (state == ST_DONE);
   assign bus_ad_oe  = addr_phase || (data_phase && wr_lat);
   assign bus_ad_out = addr_phase ? addr_lat : (wr_lat ? wdata_lat : '0);

   // R10
   wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DSTB && wr_lat) |=> $stable(bus_ad_out) && bus_ad_oe);

endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
   import mbus_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int RD_STATES  = 3,
   parameter int WR_STATES  = 2,
   parameter int EXT_STATES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              ext_mode,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [DATA_W-1:0] bus_ad_out,
   output logic              bus_ad_oe,
   input  logic [DATA_W-1:0] bus_ad_in,
   output logic              bus_as_n,
   output logic              bus_ds_n,
   output logic              bus_rw_n
);

   mbus_state_e state;
   logic        start;
   logic        last_beat;
   logic        wr_lat;
   logic        ext_lat;

   assign req_ready = (state == ST_IDLE);
   assign start     = req && req_ready;

   mbus_seq #(
      .RD_STATES  (RD_STATES),
      .WR_STATES  (WR_STATES),
      .EXT_STATES (EXT_STATES)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .is_write  (wr_lat),
      .ext_on    (ext_lat),
      .state     (state),
      .last_beat (last_beat)
   );

   mbus_dp #(
      .DATA_W (DATA_W)
   ) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .req_write  (req_write),
      .ext_mode   (ext_mode),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .state      (state),
      .last_beat  (last_beat),
      .bus_ad_in  (bus_ad_in),
      .wr_lat     (wr_lat),
      .ext_lat    (ext_lat),
      .bus_ad_out (bus_ad_out),
      .bus_ad_oe  (bus_ad_oe),
      .rdata      (rsp_rdata)
   );

   assign bus_as_n = (state != ST_ASTB);
   assign bus_ds_n = (state != ST_DSTB);
   assign bus_rw_n = (state == ST_IDLE) ? 1'b1 : !wr_lat;
   assign rsp_done = (state == ST_DONE);

   // R3
   addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_as_n) |-> $stable(bus_ad_out) && bus_ad_oe && $past(bus_ad_oe));

   // R4
   as_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_as_n |=> bus_as_n);

   // R5
   no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_ds_n && bus_rw_n) |-> !bus_ad_oe);

   // R6
   rw_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_as_n || !bus_ds_n) |=> $stable(bus_rw_n));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done && req_ready);

   // R11
   done_after_ds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_ds_n) |-> rsp_done);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> bus_as_n && bus_ds_n && bus_rw_n && !bus_ad_oe);

endmodule

// File: tb/mbus_ctrl_test.sv
module mbus_ctrl_test;

   localparam int DW  = 8;
   localparam int RDS = 3;
   localparam int WRS = 2;
   localparam int EXS = 2;

   typedef struct {
      bit          wr;
      bit          ext;
      logic [7:0]  addr;
      logic [7:0]  data;
      int          len;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [DW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          ext_mode = 1'b0;
   logic          rsp_done;
   logic [DW-1:0] rsp_rdata;
   logic [DW-1:0] bus_ad_out;
   logic          bus_ad_oe;
   logic [DW-1:0] bus_ad_in;
   logic          bus_as_n;
   logic          bus_ds_n;
   logic          bus_rw_n;

   int checks = 0;
   int failures = 0;
   int n_push = 0;
   int as_falls = 0;
   bit finished = 0;

   logic [7:0] mem [256];
   logic [7:0] ref_mem [256];
   item_t      exp_q [$];

   logic [7:0] cur_addr = '0;
   logic [7:0] float_ad = '0;
   logic [7:0] last_read = '0;
   logic       rw_at_as = 1'b1;
   int         ds_cnt = 0;
   logic       p_as = 1'b1, p_oe = 1'b0, p_done = 1'b0;
   logic [7:0] p_ad = '0;

   always #2.5 clk = ~clk;

   mbus_ctrl #(.DATA_W(DW), .RD_STATES(RDS), .WR_STATES(WRS), .EXT_STATES(EXS)) uut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .ext_mode(ext_mode), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
      .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n), .bus_rw_n(bus_rw_n)
   );

   assign bus_ad_in = (!bus_ds_n && bus_rw_n) ? mem[cur_addr] : 8'h5A;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", rq, act, exp, $time);
      end
   endtask

   task automatic do_req(input bit wr, input logic [7:0] a, input logic [7:0] d, input bit ext);
      item_t it;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req = 1'b1; req_write = wr; req_addr = a; req_wdata = d; ext_mode = ext;
      it.wr = wr; it.ext = ext; it.addr = a;
      if (wr) begin
         ref_mem[a] = d;
         it.data = d;
      end else begin
         it.data = ref_mem[a];
      end
      it.len = (wr ? WRS : RDS) + (ext ? EXS : 0);
      exp_q.push_back(it);
      n_push++;
      @(negedge clk);
      req = 1'b0;
   endtask

   // raise a request while the block is busy; it must be ignored
   task automatic poke_busy(input logic [7:0] a);
      @(negedge clk);
      while (req_ready) @(negedge clk);
      req = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = 8'h99; ext_mode = 1'b0;
      @(negedge clk);
      req = 1'b0;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (p_done)
            chk(!rsp_done && req_ready, "R11 done one clock then ready", {rsp_done, req_ready}, 2'b01);
         if (!bus_as_n) begin
            as_falls++;
            chk(p_as == 1'b1, "R4 strobe low one state", p_as, 1);
            chk(p_oe && p_ad == bus_ad_out && bus_ad_oe, "R3 address setup and hold", bus_ad_out, p_ad);
            cur_addr = bus_ad_out;
            rw_at_as = bus_rw_n;
         end
         if (!p_as && bus_as_n) begin
            chk(bus_ds_n, "R5 turnaround state", bus_ds_n, 1);
            if (bus_rw_n) chk(!bus_ad_oe, "R5 bus floated in read", bus_ad_oe, 0);
            else chk(bus_ad_oe, "R10 write data driven early", bus_ad_oe, 1);
            float_ad = bus_ad_out;
         end
         if (!bus_ds_n) begin
            ds_cnt++;
            chk(bus_rw_n == rw_at_as, "R6 direction held", bus_rw_n, rw_at_as);
            if (bus_rw_n) chk(!bus_ad_oe, "R5 no drive during read", bus_ad_oe, 0);
            else chk(bus_ad_oe && bus_ad_out == float_ad, "R10 write data stable", bus_ad_out, float_ad);
         end
         if (rsp_done) begin
            item_t it;
            chk(bus_ds_n && bus_rw_n == rw_at_as, "R6 direction held after strobe", bus_rw_n, rw_at_as);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected cycle", 0, 1);
            end else begin
               it = exp_q.pop_front();
               chk(cur_addr == it.addr, "R3 address value", cur_addr, it.addr);
               chk(rw_at_as == !it.wr, "R6 direction value", rw_at_as, !it.wr);
               if (it.ext) chk(ds_cnt == it.len, "R8 extended strobe width", ds_cnt, it.len);
               else chk(ds_cnt == it.len, "R7 strobe width", ds_cnt, it.len);
               if (it.wr) begin
                  chk(bus_ad_oe && bus_ad_out == it.data, "R10 write data hold", bus_ad_out, it.data);
                  chk(rsp_rdata == last_read, "R9 read data kept over write", rsp_rdata, last_read);
                  mem[cur_addr] = bus_ad_out;
               end else begin
                  chk(rsp_rdata == it.data, "R9 read data", rsp_rdata, it.data);
                  last_read = it.data;
               end
            end
            ds_cnt = 0;
         end
         p_as = bus_as_n; p_oe = bus_ad_oe; p_ad = bus_ad_out; p_done = rsp_done;
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin : main
      for (int i = 0; i < 256; i++) begin
         mem[i] = 8'((i * 37) ^ 8'hC3);
         ref_mem[i] = 8'((i * 37) ^ 8'hC3);
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(bus_as_n && bus_ds_n && bus_rw_n && !bus_ad_oe && req_ready && !rsp_done,
          "R1 reset state", {bus_as_n, bus_ds_n, bus_rw_n, bus_ad_oe, req_ready, rsp_done}, 6'b111010);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && bus_as_n && !bus_ad_oe, "R1 idle after reset", req_ready, 1);

      do_req(1'b0, 8'h10, 8'h00, 1'b0);
      do_req(1'b0, 8'hFF, 8'h00, 1'b0);
      do_req(1'b1, 8'h20, 8'hA5, 1'b0);
      do_req(1'b0, 8'h20, 8'h00, 1'b0);
      do_req(1'b1, 8'h00, 8'h3C, 1'b1);
      do_req(1'b0, 8'h00, 8'h00, 1'b1);
      do_req(1'b0, 8'h7E, 8'h00, 1'b1);
      do_req(1'b1, 8'h81, 8'hFF, 1'b0);
      poke_busy(8'hEE);
      do_req(1'b1, 8'h82, 8'h00, 1'b1);
      do_req(1'b0, 8'hEE, 8'h00, 1'b0);
      do_req(1'b0, 8'h81, 8'h00, 1'b0);
      do_req(1'b0, 8'h82, 8'h00, 1'b0);

      while (exp_q.size() != 0 || !req_ready) @(negedge clk);
      repeat (5) @(negedge clk);
      // R2: only accepted requests produced bus cycles
      chk(as_falls == n_push, "R2 cycles equal accepted requests", as_falls, n_push);
      chk(req_ready && bus_as_n && bus_ds_n && bus_rw_n && !bus_ad_oe, "R1 idle between cycles", req_ready, 1);
      finish_run();
   end

endmodule